// File: doc/BRIEF.md
# Processor Trap Sequencer

This block closes every instruction cycle of a small 32-bit processor. The execute logic reports a completing instruction. That report may carry a synchronous trap request with a 4-bit cause, a faulting memory address, a privileged special-register access, or new condition codes. The block then settles what the program counter becomes next and whether the instruction may commit its results. It owns the program counter register, the processor status word (current privilege level, saved level, condition codes) and three special registers. These are the trap return address, the trap fault address and a free scratch word.

When an instruction traps, it is killed before it commits, and its own address is saved. The current level moves into the saved-level field, the level drops to the most permissive value, and the program counter jumps to a vector. The vector is formed by placing a 4-bit code in PC bits 7:4. An external controller posts interrupt codes into a one-deep pending slot. A pending interrupt is taken only at the end of an instruction that did not trap. A special-register read whose destination is register 0 loads the program counter from the selected register and restores the saved level. This is the trap return.

Top module: `trap_unit`

## Requirements
- R1: When `step_valid` is high and a trap is taken (`trap_req`, or the case in R5), `retire` is low in that cycle. The trap return register then holds `cur_pc`, and neither condition codes nor any special register other than those named in R2/R3 change.
- R2: A trap with cause code 1 (bus error) loads `fault_addr` into the fault address register. A trap with any other cause leaves that register unchanged.
- R3: On trap entry, the saved-level field takes the current level, and the level field becomes 0000.
- R4: The PC after a trap or interrupt entry is zero except for bits 7:4, which hold the cause or interrupt code (cause 0 gives 0x00, 1 gives 0x10, 2 gives 0x20, 3 gives 0x30).
- R5: A special-register access (`sr_op` 1 = get, 2 = set) at level 1111 does not execute. It raises a trap with cause 3, unless `trap_req` supplies its own cause in that cycle.
- R6: A get (`sr_op`=1) with `sr_dst_zero` high loads the PC from the selected register and copies the saved level into the level field.
- R7: A synchronous trap wins over a pending interrupt in the same cycle, and the interrupt stays pending. At the end of a non-trapping instruction, a pending interrupt is taken and cleared. The PC the instruction would have moved to is saved as the trap return. `irq_post` loads code `irq_code` into the slot.
- R8: Selector map: 1 status word, 2 trap return, 3 fault address, 4 scratch. The other 12 selectors read zero, and writes to them have no effect. The scratch register is plain storage.
- R9: The status word has level in bits 31:28, saved level in 27:24 and N,Z,V,C in 3:0, and all other bits read zero. A retiring instruction with `cc_we` loads `cc_in` into 3:0.
- R10: Synchronous active-low reset sets the PC, the status word, every special register and the pending slot to zero.
- R11: With `step_valid` low, the PC, status word and special registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_valid | input | 1 | An instruction ends this cycle |
| cur_pc | input | 32 | Address of the ending instruction |
| next_pc | input | 32 | PC the instruction moves to if it completes |
| trap_req | input | 1 | Execute logic detected a trap |
| trap_cause | input | 4 | Cause code of that trap |
| fault_addr | input | 32 | Offending memory address for a bus error |
| sr_op | input | 2 | 0 none, 1 get, 2 set |
| sr_sel | input | 4 | Special register selector |
| sr_dst_zero | input | 1 | Get targets register 0 (trap return) |
| sr_wdata | input | 32 | Value for a set |
| cc_we | input | 1 | Instruction updates condition codes |
| cc_in | input | 4 | New N,Z,V,C |
| irq_post | input | 1 | Controller posts an interrupt |
| irq_code | input | 4 | Code of the posted interrupt |
| pc | output | 32 | Program counter register |
| psw | output | 32 | Processor status word |
| sr_rdata | output | 32 | Selected special register, combinational |
| retire | output | 1 | Instruction may commit its results |
| trap_taken | output | 1 | A trap or interrupt is entered this cycle |
| irq_pending | output | 1 | An interrupt is waiting |

## Verification
The bench uses the default parameters: a 32-bit word, a 4-bit code placed at PC bits 7:4, and 16 selectors. With these, every vector address and every selector, including the unused ones, can be exercised. At the 4-bit level width, the locked value 1111 is reached by writes to the status word. The randomized phase therefore hits privilege traps, interrupts colliding with traps, and trap returns mixed with condition-code updates.

// File: rtl/trap_pkg.sv
// Shared codes for the trap sequencer.
// Assumes a 4-bit level field and 4-bit cause codes.
package trap_pkg;
    localparam int CODE_W = 4;
    localparam int LVL_W  = 4;
    localparam int SEL_W  = 4;

    localparam logic [1:0] OP_NONE = 2'd0;
    localparam logic [1:0] OP_GET  = 2'd1;
    localparam logic [1:0] OP_SET  = 2'd2;

    localparam logic [CODE_W-1:0] CAUSE_RESET = 4'd0;
    localparam logic [CODE_W-1:0] CAUSE_BUS   = 4'd1;
    localparam logic [CODE_W-1:0] CAUSE_ILL   = 4'd2;
    localparam logic [CODE_W-1:0] CAUSE_PRIV  = 4'd3;

    localparam logic [SEL_W-1:0] SEL_PSW = 4'd1;
    localparam logic [SEL_W-1:0] SEL_TPC = 4'd2;
    localparam logic [SEL_W-1:0] SEL_TMA = 4'd3;
    localparam logic [SEL_W-1:0] SEL_TSV = 4'd4;

    localparam logic [LVL_W-1:0] LVL_LOCKED = 4'hF;
endpackage

// File: rtl/trap_decide.sv
// Decides, for the ending instruction, whether a synchronous trap,
// an interrupt or a normal completion happens. Purely combinational.
// Assumes the inputs are stable before the clock edge.
module trap_decide
    import trap_pkg::*;
(
    input  logic              step_valid,
    input  logic              trap_req,
    input  logic [CODE_W-1:0] trap_cause,
    input  logic [1:0]        sr_op,
    input  logic [LVL_W-1:0]  level,
    input  logic              irq_pend,
    output logic              take_sync,
    output logic              take_irq,
    output logic [CODE_W-1:0] sync_code,
    output logic              retire
);
    logic priv_fault;

    // classify the ending instruction
    always_comb begin
        priv_fault = (sr_op != OP_NONE) && (level == LVL_LOCKED);
        take_sync  = step_valid && (trap_req || priv_fault);
        sync_code  = trap_req ? trap_cause : CAUSE_PRIV;
        take_irq   = step_valid && !take_sync && irq_pend;
        retire     = step_valid && !take_sync;
    end
endmodule

// File: rtl/trap_irq_slot.sv
// One-deep holding slot for a posted interrupt code.
// A new post overrides both a waiting code and a same-cycle take.
module trap_irq_slot
    import trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_post,
    input  logic [CODE_W-1:0] irq_code_in,
    input  logic              take_irq,
    output logic              pend_q,
    output logic [CODE_W-1:0] code_q
);
    // hold, fill or drain the slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            code_q <= '0;
        end else if (irq_post) begin
            pend_q <= 1'b1;
            code_q <= irq_code_in;
        end else if (take_irq) begin
            pend_q <= 1'b0;
        end
    end

    assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && !irq_post) |=> !pend_q);
    assert_reset_R10: assert property (@(posedge clk)
        !rst_n |=> !pend_q);
endmodule

// File: rtl/trap_state.sv
// Architectural state: PC, status word fields, trap return, fault
// address and scratch register. It applies trap entry, interrupt entry,
// special-register sets and the register-0 get return.
// Assumes XLEN >= 12 and VEC_LSB + CODE_W <= XLEN.
module trap_state
    import trap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int VEC_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_valid,
    input  logic              take_sync,
    input  logic [CODE_W-1:0] sync_code,
    input  logic              take_irq,
    input  logic [CODE_W-1:0] irq_code,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   next_pc,
    input  logic [XLEN-1:0]   fault_addr,
    input  logic [1:0]        sr_op,
    input  logic [SEL_W-1:0]  sr_sel,
    input  logic              sr_dst_zero,
    input  logic [XLEN-1:0]   sr_wdata,
    input  logic              cc_we,
    input  logic [3:0]        cc_in,
    output logic [XLEN-1:0]   pc,
    output logic [LVL_W-1:0]  level,
    output logic [XLEN-1:0]   psw,
    output logic [XLEN-1:0]   sr_rdata
);
    localparam int PAD_W = XLEN - 2*LVL_W - 4;

    logic [XLEN-1:0]  pc_q, tpc_q, tma_q, tsv_q;
    logic [LVL_W-1:0] lvl_q, old_q;
    logic [3:0]       cc_q;
    logic [XLEN-1:0]  n_pc, n_tpc, n_tma, n_tsv;
    logic [LVL_W-1:0] n_lvl, n_old;
    logic [3:0]       n_cc;

    function automatic logic [XLEN-1:0] vec_pc(input logic [CODE_W-1:0] c);
        logic [XLEN-1:0] v;
        v = '0;
        v[VEC_LSB +: CODE_W] = c;
        return v;
    endfunction

    // assemble the status word
    always_comb psw = {lvl_q, old_q, {PAD_W{1'b0}}, cc_q};

    // special register read port
    always_comb begin
        case (sr_sel)
            SEL_PSW: sr_rdata = psw;
            SEL_TPC: sr_rdata = tpc_q;
            SEL_TMA: sr_rdata = tma_q;
            SEL_TSV: sr_rdata = tsv_q;
            default: sr_rdata = '0;
        endcase
    end

    // next-state selection for all architectural registers
    always_comb begin
        n_pc = pc_q; n_lvl = lvl_q; n_old = old_q; n_cc = cc_q;
        n_tpc = tpc_q; n_tma = tma_q; n_tsv = tsv_q;
        if (step_valid) begin
            if (take_sync) begin
                n_tpc = cur_pc;
                if (sync_code == CAUSE_BUS) n_tma = fault_addr;
                n_old = lvl_q;
                n_lvl = '0;
                n_pc  = vec_pc(sync_code);
            end else begin
                n_pc = next_pc;
                if (cc_we) n_cc = cc_in;
                if (sr_op == OP_SET) begin
                    case (sr_sel)
                        SEL_PSW: begin
                            n_lvl = sr_wdata[XLEN-1 -: LVL_W];
                            n_old = sr_wdata[XLEN-LVL_W-1 -: LVL_W];
                            n_cc  = sr_wdata[3:0];
                        end
                        SEL_TPC: n_tpc = sr_wdata;
                        SEL_TMA: n_tma = sr_wdata;
                        SEL_TSV: n_tsv = sr_wdata;
                        default: ;
                    endcase
                end else if (sr_op == OP_GET && sr_dst_zero) begin
                    n_pc  = sr_rdata;
                    n_lvl = old_q;
                end
                if (take_irq) begin
                    n_tpc = n_pc;
                    n_old = n_lvl;
                    n_lvl = '0;
                    n_pc  = vec_pc(irq_code);
                end
            end
        end
    end

    // state registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0; lvl_q <= '0; old_q <= '0; cc_q <= '0;
            tpc_q <= '0; tma_q <= '0; tsv_q <= '0;
        end else begin
            pc_q <= n_pc; lvl_q <= n_lvl; old_q <= n_old; cc_q <= n_cc;
            tpc_q <= n_tpc; tma_q <= n_tma; tsv_q <= n_tsv;
        end
    end

    always_comb begin
        pc    = pc_q;
        level = lvl_q;
    end

    assert_trap_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        take_sync |=> tpc_q == $past(cur_pc));
    assert_tma_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_sync && sync_code != CAUSE_BUS) |=> $stable(tma_q));
    assert_level_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_sync |=> (lvl_q == '0) && (old_q == $past(lvl_q)));
    assert_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_sync |=> pc_q == vec_pc($past(sync_code)));
    assert_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !take_sync && !take_irq && sr_op == OP_GET && sr_dst_zero)
        |=> lvl_q == $past(old_q));
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !step_valid |=> $stable(pc_q) && $stable(psw) && $stable(tsv_q));
endmodule

// File: rtl/trap_unit.sv
// Trap sequencer top: connects the decision logic, the interrupt slot
// and the architectural state. Evaluated once per ending instruction.
module trap_unit
    import trap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int VEC_LSB = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_valid,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] next_pc,
    input  logic            trap_req,
    input  logic [3:0]      trap_cause,
    input  logic [XLEN-1:0] fault_addr,
    input  logic [1:0]      sr_op,
    input  logic [3:0]      sr_sel,
    input  logic            sr_dst_zero,
    input  logic [XLEN-1:0] sr_wdata,
    input  logic            cc_we,
    input  logic [3:0]      cc_in,
    input  logic            irq_post,
    input  logic [3:0]      irq_code,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] psw,
    output logic [XLEN-1:0] sr_rdata,
    output logic            retire,
    output logic            trap_taken,
    output logic            irq_pending
);
    logic              take_sync, take_irq, pend_q;
    logic [CODE_W-1:0] sync_code, pend_code;
    logic [LVL_W-1:0]  level;

    trap_decide u_decide (
        .step_valid (step_valid), .trap_req (trap_req), .trap_cause (trap_cause),
        .sr_op (sr_op), .level (level), .irq_pend (pend_q),
        .take_sync (take_sync), .take_irq (take_irq), .sync_code (sync_code),
        .retire (retire)
    );

    trap_irq_slot u_slot (
        .clk (clk), .rst_n (rst_n), .irq_post (irq_post), .irq_code_in (irq_code),
        .take_irq (take_irq), .pend_q (pend_q), .code_q (pend_code)
    );

    trap_state #(.XLEN (XLEN), .VEC_LSB (VEC_LSB)) u_state (
        .clk (clk), .rst_n (rst_n), .step_valid (step_valid),
        .take_sync (take_sync), .sync_code (sync_code),
        .take_irq (take_irq), .irq_code (pend_code),
        .cur_pc (cur_pc), .next_pc (next_pc), .fault_addr (fault_addr),
        .sr_op (sr_op), .sr_sel (sr_sel), .sr_dst_zero (sr_dst_zero),
        .sr_wdata (sr_wdata), .cc_we (cc_we), .cc_in (cc_in),
        .pc (pc), .level (level), .psw (psw), .sr_rdata (sr_rdata)
    );

    // report any control transfer to a vector
    always_comb begin
        trap_taken  = take_sync || take_irq;
        irq_pending = pend_q;
    end

    assert_priv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !trap_req && sr_op != OP_NONE && level == LVL_LOCKED)
        |=> pc == XLEN'(32'h30));
    assert_sync_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && trap_req && pend_q) |=> pend_q);
endmodule

// File: tb/tb_trap_unit.sv
// Self-checking bench: directed corner cases, then seeded random cycles
// compared with a reference model kept in bench variables.
module tb_trap_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        step_valid, trap_req, sr_dst_zero, cc_we, irq_post;
    logic [31:0] cur_pc, next_pc, fault_addr, sr_wdata;
    logic [3:0]  trap_cause, sr_sel, cc_in, irq_code;
    logic [1:0]  sr_op;
    logic [31:0] pc, psw, sr_rdata;
    logic        retire, trap_taken, irq_pending;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [31:0] m_pc, m_tpc, m_tma, m_tsv;
    logic [3:0]  m_lvl, m_old, m_cc, m_code;
    logic        m_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_unit dut (
        .clk (clk), .rst_n (rst_n), .step_valid (step_valid), .cur_pc (cur_pc),
        .next_pc (next_pc), .trap_req (trap_req), .trap_cause (trap_cause),
        .fault_addr (fault_addr), .sr_op (sr_op), .sr_sel (sr_sel),
        .sr_dst_zero (sr_dst_zero), .sr_wdata (sr_wdata), .cc_we (cc_we),
        .cc_in (cc_in), .irq_post (irq_post), .irq_code (irq_code),
        .pc (pc), .psw (psw), .sr_rdata (sr_rdata), .retire (retire),
        .trap_taken (trap_taken), .irq_pending (irq_pending)
    );

    function automatic logic [31:0] m_psw();
        return {m_lvl, m_old, 20'd0, m_cc};
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] s);
        case (s)
            4'd1: return m_psw();
            4'd2: return m_tpc;
            4'd3: return m_tma;
            4'd4: return m_tsv;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] vec(input logic [3:0] c);
        return {24'd0, c, 4'd0};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        step_valid = 0; trap_req = 0; trap_cause = 0; fault_addr = 0;
        sr_op = 0; sr_sel = 0; sr_dst_zero = 0; sr_wdata = 0;
        cc_we = 0; cc_in = 0; irq_post = 0; irq_code = 0;
        cur_pc = 0; next_pc = 0;
    endtask

    task automatic model_reset();
        m_pc = 0; m_tpc = 0; m_tma = 0; m_tsv = 0;
        m_lvl = 0; m_old = 0; m_cc = 0; m_code = 0; m_pend = 0;
    endtask

    task automatic check_state(input string tag);
        chk(tag, "pc", pc, m_pc);
        chk(tag, "psw", psw, m_psw());
        chk(tag, "irq_pending", {31'd0, irq_pending}, {31'd0, m_pend});
    endtask

    // one instruction-end cycle: check combinational outputs, clock, check state
    task automatic cycle(input string tag);
        logic        priv, sync, irq;
        logic [3:0]  code;
        logic [31:0] n_pc, n_tpc, n_tma, n_tsv;
        logic [3:0]  n_lvl, n_old, n_cc;
        #1;
        priv = (sr_op != 2'd0) && (m_lvl == 4'hF);
        sync = step_valid && (trap_req || priv);
        code = trap_req ? trap_cause : 4'd3;
        irq  = step_valid && !sync && m_pend;
        chk(tag, "retire", {31'd0, retire}, {31'd0, step_valid && !sync});
        chk(tag, "sr_rdata", sr_rdata, m_read(sr_sel));
        n_pc = m_pc; n_tpc = m_tpc; n_tma = m_tma; n_tsv = m_tsv;
        n_lvl = m_lvl; n_old = m_old; n_cc = m_cc;
        if (sync) begin
            n_tpc = cur_pc;
            if (code == 4'd1) n_tma = fault_addr;
            n_old = m_lvl; n_lvl = 0; n_pc = vec(code);
        end else if (step_valid) begin
            n_pc = next_pc;
            if (cc_we) n_cc = cc_in;
            if (sr_op == 2'd2) begin
                case (sr_sel)
                    4'd1: begin n_lvl = sr_wdata[31:28]; n_old = sr_wdata[27:24]; n_cc = sr_wdata[3:0]; end
                    4'd2: n_tpc = sr_wdata;
                    4'd3: n_tma = sr_wdata;
                    4'd4: n_tsv = sr_wdata;
                    default: ;
                endcase
            end else if (sr_op == 2'd1 && sr_dst_zero) begin
                n_pc = m_read(sr_sel); n_lvl = m_old;
            end
            if (irq) begin
                n_tpc = n_pc; n_old = n_lvl; n_lvl = 0; n_pc = vec(m_code);
            end
        end
        @(posedge clk);
        #1;
        m_pc = n_pc; m_tpc = n_tpc; m_tma = n_tma; m_tsv = n_tsv;
        m_lvl = n_lvl; m_old = n_old; m_cc = n_cc;
        if (irq_post) begin m_pend = 1; m_code = irq_code; end
        else if (irq) m_pend = 0;
        check_state(tag);
        idle();
    endtask

    task automatic do_reset(input string tag);
        rst_n = 0;
        @(posedge clk); @(posedge clk); #1;
        model_reset();
        check_state(tag);
        rst_n = 1;
    endtask

    task automatic read_sel(input logic [3:0] s, input logic [31:0] exp, input string tag);
        sr_sel = s; #1;
        chk(tag, "read", sr_rdata, exp);
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        idle();
        model_reset();
        do_reset("R10");
        for (int s = 1; s < 5; s++) read_sel(4'(s), 32'd0, "R10");

        // R8: scratch storage and unused selectors
        step_valid = 1; next_pc = 32'h104; sr_op = 2; sr_sel = 4; sr_wdata = 32'hCAFEF00D;
        cycle("R8");
        read_sel(4, 32'hCAFEF00D, "R8");
        step_valid = 1; next_pc = 32'h108; sr_op = 2; sr_sel = 7; sr_wdata = 32'h12345678;
        cycle("R8");
        read_sel(7, 32'd0, "R8");
        read_sel(4, 32'hCAFEF00D, "R8");

        // R9: status word layout and condition codes
        step_valid = 1; next_pc = 32'h10C; sr_op = 2; sr_sel = 1; sr_wdata = 32'h5FFF_FFFA;
        cycle("R9");
        chk("R9", "psw masked", psw, 32'h5F00_000A);
        step_valid = 1; next_pc = 32'h110; cc_we = 1; cc_in = 4'h3;
        cycle("R9");

        // R1/R3/R4: illegal instruction trap, cc write suppressed
        step_valid = 1; cur_pc = 32'h1234; next_pc = 32'h1238; trap_req = 1; trap_cause = 2;
        cc_we = 1; cc_in = 4'hC; sr_op = 2; sr_sel = 4; sr_wdata = 32'h0;
        cycle("R1");
        chk("R4", "vector", pc, 32'h20);
        chk("R3", "level/old", psw[31:24], 8'h05);
        read_sel(2, 32'h1234, "R1");
        read_sel(4, 32'hCAFEF00D, "R1");

        // R2: bus error latches fault address, other cause does not
        step_valid = 1; cur_pc = 32'h2000; trap_req = 1; trap_cause = 1; fault_addr = 32'hDEAD0000;
        cycle("R2");
        chk("R4", "bus vector", pc, 32'h10);
        read_sel(3, 32'hDEAD0000, "R2");
        step_valid = 1; cur_pc = 32'h2004; trap_req = 1; trap_cause = 2; fault_addr = 32'h11111111;
        cycle("R2");
        read_sel(3, 32'hDEAD0000, "R2");
        step_valid = 1; cur_pc = 32'h2008; trap_req = 1; trap_cause = 0;
        cycle("R4");
        chk("R4", "reset vector", pc, 32'h00);

        // R6: return through a register-0 get of the trap return
        step_valid = 1; next_pc = 32'h4; sr_op = 2; sr_sel = 1; sr_wdata = 32'h0700_0000;
        cycle("R6");
        step_valid = 1; next_pc = 32'h8; sr_op = 1; sr_sel = 2; sr_dst_zero = 1;
        cycle("R6");
        chk("R6", "return pc", pc, 32'h2008);
        chk("R6", "restored level", {28'd0, psw[31:28]}, 32'd7);

        // R5: privileged access at level 1111
        step_valid = 1; next_pc = 32'h200C; sr_op = 2; sr_sel = 1; sr_wdata = 32'hF200_0000;
        cycle("R5");
        step_valid = 1; cur_pc = 32'h3000; next_pc = 32'h3004; sr_op = 2; sr_sel = 4; sr_wdata = 32'h0;
        cycle("R5");
        chk("R5", "priv vector", pc, 32'h30);
        read_sel(4, 32'hCAFEF00D, "R5");
        chk("R5", "old level", {28'd0, psw[27:24]}, 32'hF);

        // R7: trap beats pending interrupt, then interrupt taken
        irq_post = 1; irq_code = 4'd5;
        cycle("R7");
        step_valid = 1; cur_pc = 32'h40; trap_req = 1; trap_cause = 2;
        cycle("R7");
        chk("R7", "still pending", {31'd0, irq_pending}, 32'd1);
        step_valid = 1; cur_pc = 32'h20; next_pc = 32'h24;
        cycle("R7");
        chk("R7", "irq vector", pc, 32'h50);
        read_sel(2, 32'h24, "R7");

        // R11: no instruction end, state holds
        cur_pc = 32'h999; next_pc = 32'h777; trap_req = 1; trap_cause = 1;
        sr_op = 2; sr_sel = 4; sr_wdata = 32'h1; cc_we = 1; cc_in = 4'hF;
        cycle("R11");
        chk("R11", "pc held", pc, 32'h50);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            step_valid  = ($urandom % 8) != 0;
            cur_pc      = $urandom;
            next_pc     = $urandom;
            trap_req    = ($urandom % 6) == 0;
            trap_cause  = 4'($urandom);
            fault_addr  = $urandom;
            sr_op       = 2'($urandom % 3);
            sr_sel      = 4'($urandom % 8);
            sr_dst_zero = 1'($urandom);
            sr_wdata    = $urandom;
            cc_we       = 1'($urandom);
            cc_in       = 4'($urandom);
            irq_post    = ($urandom % 10) == 0;
            irq_code    = 4'($urandom);
            cycle("RND");
        end

        // reset after activity
        do_reset("R10");
        read_sel(2, 32'd0, "R10");
        read_sel(4, 32'd0, "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule